// File: doc/BRIEF.md
# Rate-Trimmed Nanosecond Time-of-Day Counter

This block keeps a 64-bit time-of-day value, counted in nanoseconds, that runs from the reference clock. The rate is set by a 32-bit phase accumulator. On every enabled reference cycle a programmable addend is added to the accumulator, modulo 2^32. Whenever that sum carries out of bit 31, the time value advances by a programmable nanosecond step. The addend's nominal value is the ceiling of 2^32 times the nominal frequency divided by the reference frequency. The step is 10^9 divided by the nominal frequency, where the nominal frequency lies below the reference frequency and divides 1000 MHz evenly. Fractional rates are therefore expressed in the addend and not in the increment.

Software reaches the block through a small word-wide register port with four registers:

| Address | Register | Contents |
|---|---|---|
| 0 | control | bit 0 is the run enable; bits 8 and up hold the nanosecond step |
| 1 | addend | the 32-bit accumulator addend |
| 2 | count, lower word | bits 31:0 of the time value |
| 3 | count, upper word | bits 63:32 of the time value |

The time value is read lower word first, then upper word. Reading the lower word captures the upper word into a shadow register, so the pair that comes back is one coherent 64-bit sample. The time value is written lower word first, then upper word. The lower word waits in a staging register, and the upper-word write loads all 64 bits in one cycle. The accumulator keeps its fraction across that load. The addend may be rewritten while the counter runs, which trims the rate without a pause.

Top module: `ns_timebase`

## Requirements
- R1: After reset the time value is 0, the run enable is 0, the step reads back as `PERIOD_RST` and the addend reads back as `ADDEND_RST`.
- R2: While the run enable (control bit 0) is 0, the time value and the accumulator do not change.
- R3: On each reference cycle with the run enable at 1, the accumulator becomes (accumulator + addend) mod 2^32. When that addition carries out of bit 31, the time value grows by exactly the step in that cycle. It never grows by more than one step per cycle.
- R4: An addend of 0 never advances the time value. An addend of 0xFFFF_FFFF advances it on every cycle except when the accumulator is 0.
- R5: A read at address 2 returns the live lower word and captures the upper word of that same instant into a shadow register. A read at address 3 returns that shadow, whatever the counter has done since.
- R6: A write at address 2 alone leaves the time value unchanged. The following write at address 3 loads {upper data, staged lower data} in a single cycle.
- R7: A load does not clear or alter the accumulator fraction, so carries after a load follow the accumulator state from before it.
- R8: A new addend written while running takes effect from the next cycle, and counting does not pause.
- R9: The time value counts as one 64-bit number, so a carry out of the lower word increments the upper word.
- R10: The control register (step in bits 8 to 8+PERIOD_W-1, enable in bit 0, other bits reading 0) and the addend register read back the values last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | reference clock |
| rstN | input | 1 | active-low synchronous reset |
| regWrEn | input | 1 | register write strobe |
| regRdEn | input | 1 | register read strobe (a lower-word read captures the shadow) |
| regAddr | input | 2 | register select: 0 control, 1 addend, 2 count lower word, 3 count upper word |
| regWrData | input | 32 | write data |
| regRdData | output | 32 | read data for regAddr, valid in the same cycle |

## Verification
The counter is exercised with addends of 2^31, which gives a carry every other cycle, 0xFFFF_FFFF, which gives a carry nearly every cycle, 0, which never carries, and 0x6000_0000, an irregular carry pattern. Comparing each against a cycle model tells a wrong carry position or a double step apart from correct counting. A load in the middle of a run separates a design that keeps the fraction from one that clears it. A run started just below a 32-bit boundary shows whether the carry reaches the upper word. A lower-word read followed by an upper-word read taken after that boundary has passed shows whether the shadow gives a torn or a coherent value.

// File: rtl/ns_timebase_pkg.sv
package ns_timebase_pkg;
  localparam int CNT_W  = 64;
  localparam int WORD_W = 32;

  typedef enum logic [1:0] {
    ADDR_CTRL   = 2'd0,
    ADDR_ADDEND = 2'd1,
    ADDR_CNT_LO = 2'd2,
    ADDR_CNT_HI = 2'd3
  } reg_addr_e;

  // Strobes from the register control to the datapath
  typedef struct packed {
    logic cntEn;    // run enable
    logic loadCnt;  // load the 64-bit time value this cycle
  } dp_strobe_t;
endpackage

// File: rtl/ns_timebase_ctrl.sv
module ns_timebase_ctrl
  import ns_timebase_pkg::*;
#(
  parameter int              PERIOD_W   = 8,
  parameter logic [PERIOD_W-1:0] PERIOD_RST = 8'd5,
  parameter logic [WORD_W-1:0]   ADDEND_RST = 32'hCCCC_CCCD
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrEn,
  input  logic                regRdEn,
  input  logic [1:0]          regAddr,
  input  logic [WORD_W-1:0]   regWrData,
  input  logic [CNT_W-1:0]    cnt,
  output dp_strobe_t          strobes,
  output logic [CNT_W-1:0]    loadVal,
  output logic [WORD_W-1:0]   addend,
  output logic [PERIOD_W-1:0] period,
  output logic [WORD_W-1:0]   regRdData
);
  localparam int STEP_LSB = 8;

  logic              runEn;
  logic [WORD_W-1:0] stageLo;
  logic [WORD_W-1:0] shadowHi;
  logic [WORD_W-1:0] ctrlWord;

  logic wrCtrl, wrAddend, wrLo, wrHi, rdLo;
  assign wrCtrl   = regWrEn && (regAddr == ADDR_CTRL);
  assign wrAddend = regWrEn && (regAddr == ADDR_ADDEND);
  assign wrLo     = regWrEn && (regAddr == ADDR_CNT_LO);
  assign wrHi     = regWrEn && (regAddr == ADDR_CNT_HI);
  assign rdLo     = regRdEn && (regAddr == ADDR_CNT_LO);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runEn    <= 1'b0;
      period   <= PERIOD_RST;
      addend   <= ADDEND_RST;
      stageLo  <= '0;
      shadowHi <= '0;
    end else begin
      if (wrCtrl) begin
        runEn  <= regWrData[0];
        period <= regWrData[STEP_LSB +: PERIOD_W];
      end
      if (wrAddend) addend  <= regWrData;
      if (wrLo)     stageLo <= regWrData;
      if (rdLo)     shadowHi <= cnt[CNT_W-1:WORD_W];
    end
  end

  assign strobes.cntEn   = runEn;
  assign strobes.loadCnt = wrHi;
  assign loadVal         = {regWrData, stageLo};

  always_comb begin
    ctrlWord = '0;
    ctrlWord[0] = runEn;
    ctrlWord[STEP_LSB +: PERIOD_W] = period;
  end

  always_comb begin
    unique case (regAddr)
      ADDR_CTRL:   regRdData = ctrlWord;
      ADDR_ADDEND: regRdData = addend;
      ADDR_CNT_LO: regRdData = cnt[WORD_W-1:0];
      default:     regRdData = shadowHi;
    endcase
  end

  // R5: the shadow holds the upper word seen at the lower-word read
  p_shadow_capture_r5: assert property (@(posedge clk) disable iff (!rstN)
    rdLo |=> shadowHi == $past(cnt[CNT_W-1:WORD_W]));
  // R5: without a lower-word read the shadow holds its value
  p_shadow_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !rdLo |=> $stable(shadowHi));
  // R2: clearing bit 0 stops the run enable from the next cycle
  p_enable_off_r2: assert property (@(posedge clk) disable iff (!rstN)
    (wrCtrl && !regWrData[0]) |=> !strobes.cntEn);
endmodule

// File: rtl/ns_timebase_dp.sv
module ns_timebase_dp
  import ns_timebase_pkg::*;
#(
  parameter int PERIOD_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  dp_strobe_t          strobes,
  input  logic [CNT_W-1:0]    loadVal,
  input  logic [WORD_W-1:0]   addend,
  input  logic [PERIOD_W-1:0] period,
  output logic [CNT_W-1:0]    cnt
);
  logic [WORD_W-1:0] phaseAcc;
  logic [WORD_W:0]   phaseSum;
  logic              carry;
  logic [CNT_W-1:0]  cntStepped;

  // The carry is bit 32 of the 33-bit sum
  assign phaseSum   = {1'b0, phaseAcc} + {1'b0, addend};
  assign carry      = strobes.cntEn && phaseSum[WORD_W];
  assign cntStepped = cnt + CNT_W'(period);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseAcc <= '0;
      cnt      <= '0;
    end else begin
      if (strobes.cntEn) phaseAcc <= phaseSum[WORD_W-1:0];
      if (strobes.loadCnt) cnt <= loadVal;
      else if (carry)      cnt <= cntStepped;
    end
  end

  // R3: a carry without a load adds exactly one step
  p_one_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (carry && !strobes.loadCnt) |=> (cnt - $past(cnt)) == CNT_W'($past(period)));
  // R2: no run enable and no load means no change at all
  p_hold_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.cntEn && !strobes.loadCnt) |=> ($stable(cnt) && $stable(phaseAcc)));
  // R6: the load lands in the next cycle, all 64 bits at once
  p_load_atomic_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadCnt |=> cnt == $past(loadVal));
  // R7: a load while stopped leaves the fraction untouched
  p_keep_fraction_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.loadCnt && !strobes.cntEn) |=> $stable(phaseAcc));
endmodule

// File: rtl/ns_timebase.sv
module ns_timebase
  import ns_timebase_pkg::*;
#(
  parameter int                  PERIOD_W   = 8,
  parameter logic [PERIOD_W-1:0] PERIOD_RST = 8'd5,
  parameter logic [31:0]         ADDEND_RST = 32'hCCCC_CCCD
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic        regRdEn,
  input  logic [1:0]  regAddr,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData
);
  dp_strobe_t          strobes;
  logic [CNT_W-1:0]    loadVal;
  logic [CNT_W-1:0]    cnt;
  logic [WORD_W-1:0]   addend;
  logic [PERIOD_W-1:0] period;

  ns_timebase_ctrl #(
    .PERIOD_W(PERIOD_W), .PERIOD_RST(PERIOD_RST), .ADDEND_RST(ADDEND_RST)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .cnt(cnt),
    .strobes(strobes), .loadVal(loadVal), .addend(addend),
    .period(period), .regRdData(regRdData)
  );

  ns_timebase_dp #(.PERIOD_W(PERIOD_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .loadVal(loadVal),
    .addend(addend), .period(period), .cnt(cnt)
  );
endmodule

// File: tb/ns_timebase_tb.sv
`timescale 1ns/1ps
module ns_timebase_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic        regRdEn = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;

  int nChecks = 0;
  int nFails  = 0;
  bit doneFlag = 1'b0;

  always #5 clk = ~clk;

  ns_timebase dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData)
  );

  // Cycle model built from the requirements
  logic        mEn;
  logic [7:0]  mPer;
  logic [31:0] mAdd, mAcc, mStage;
  logic [63:0] mCnt;
  logic [32:0] mSum;
  always @(posedge clk) begin
    if (!rstN) begin
      mEn <= 1'b0; mPer <= 8'd5; mAdd <= 32'hCCCC_CCCD;
      mAcc <= '0; mStage <= '0; mCnt <= '0;
    end else begin
      mSum = {1'b0, mAcc} + {1'b0, mAdd};
      if (mEn) mAcc <= mSum[31:0];
      if (regWrEn && regAddr == 2'd3) mCnt <= {regWrData, mStage};
      else if (mEn && mSum[32])       mCnt <= mCnt + 64'(mPer);
      if (regWrEn && regAddr == 2'd0) begin mEn <= regWrData[0]; mPer <= regWrData[15:8]; end
      if (regWrEn && regAddr == 2'd1) mAdd <= regWrData;
      if (regWrEn && regAddr == 2'd2) mStage <= regWrData;
    end
  end

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic regWrite(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    regRdEn = 1'b1; regAddr = a;
    #1 d = regRdData;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  // Lower then upper read; returns value and the model's expectation at the lower read
  task automatic readCount(output logic [63:0] v, output logic [63:0] e);
    logic [31:0] lo, hi;
    @(negedge clk);
    regRdEn = 1'b1; regAddr = 2'd2;
    #1 lo = regRdData; e = mCnt;
    @(negedge clk);
    regRdEn = 1'b0;
    regRead(2'd3, hi);
    v = {hi, lo};
  endtask

  task automatic loadCount(logic [63:0] v);
    regWrite(2'd2, v[31:0]);
    regWrite(2'd3, v[63:32]);
  endtask

  task automatic runCycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d; logic [63:0] v, e;
    regRead(2'd0, d);  check("R1 control", 64'(d), 64'h500);
    regRead(2'd1, d);  check("R1 addend", 64'(d), 64'hCCCC_CCCD);
    readCount(v, e);   check("R1 count", v, 64'd0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    regWrite(2'd0, 32'hFFFF_0800); // reserved bits set, enable 0, step 8
    regRead(2'd0, d);  check("R10 control readback", 64'(d), 64'h0800);
    regWrite(2'd1, 32'h8000_0000);
    regRead(2'd1, d);  check("R10 addend readback", 64'(d), 64'h8000_0000);
  endtask

  task automatic t_load();
    logic [63:0] v, e;
    regWrite(2'd2, 32'h1234_5678);
    readCount(v, e);   check("R6 staged lower word not applied", v, 64'd0);
    regWrite(2'd3, 32'h0000_00AB);
    readCount(v, e);   check("R6 atomic load", v, 64'h0000_00AB_1234_5678);
  endtask

  task automatic t_hold();
    logic [63:0] v, e;
    runCycles(30);
    readCount(v, e);   check("R2 stopped counter holds", v, 64'h0000_00AB_1234_5678);
  endtask

  task automatic t_half_rate();
    logic [63:0] v, e;
    loadCount(64'd0);
    regWrite(2'd0, 32'h0000_0801);
    runCycles(40);
    regWrite(2'd0, 32'h0000_0800);
    readCount(v, e);   check("R3 addend 2^31 model", v, e);
    check("R3 whole steps only", 64'(v[2:0]), 64'd0);
  endtask

  task automatic t_full_rate();
    logic [63:0] v, e;
    regWrite(2'd1, 32'hFFFF_FFFF);
    regWrite(2'd0, 32'h0000_0301);
    runCycles(25);
    regWrite(2'd0, 32'h0000_0300);
    readCount(v, e);   check("R4 addend all ones model", v, e);
  endtask

  task automatic t_zero_addend();
    logic [63:0] v0, v1, e;
    regWrite(2'd1, 32'h0);
    readCount(v0, e);
    regWrite(2'd0, 32'h0000_0301);
    runCycles(20);
    readCount(v1, e);  check("R4 zero addend never steps", v1, v0);
    regWrite(2'd0, 32'h0000_0300);
  endtask

  task automatic t_wrap();
    logic [63:0] v, e;
    loadCount(64'h0000_0000_FFFF_FFF0);
    regWrite(2'd1, 32'hFFFF_FFFF);
    regWrite(2'd0, 32'h0000_0801);
    runCycles(12);
    regWrite(2'd0, 32'h0000_0800);
    readCount(v, e);
    check("R9 carry into upper word", 64'(v[63:32]), 64'd1);
    check("R9 model", v, e);
  endtask

  task automatic t_shadow();
    logic [31:0] lo, hi; logic [63:0] e;
    loadCount(64'h0000_0005_FFFF_FFE0);
    regWrite(2'd1, 32'hFFFF_FFFF);
    regWrite(2'd0, 32'h0000_0801);
    @(negedge clk);
    regRdEn = 1'b1; regAddr = 2'd2;
    #1 lo = regRdData; e = mCnt;
    @(negedge clk);
    regRdEn = 1'b0;
    runCycles(10);                  // lower word wraps meanwhile
    regRead(2'd3, hi);
    check("R5 lower word live", 64'(lo), 64'(e[31:0]));
    check("R5 upper word from shadow", 64'(hi), 64'd5);
    regWrite(2'd0, 32'h0000_0800);
  endtask

  task automatic t_retrim_and_fraction();
    logic [63:0] v, e;
    regWrite(2'd1, 32'h6000_0000);
    regWrite(2'd0, 32'h0000_0701);
    runCycles(9);
    loadCount(64'h0000_0100_0000_0000); // load while running
    runCycles(7);
    regWrite(2'd1, 32'hA000_0001);       // R8: trim without stopping
    runCycles(13);
    regWrite(2'd0, 32'h0000_0700);
    readCount(v, e);   check("R7 R8 fraction kept and retrim", v, e);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_regs();
    t_load();
    t_hold();
    t_half_rate();
    t_full_rate();
    t_zero_addend();
    t_wrap();
    t_shadow();
    t_retrim_and_fraction();
    if (!doneFlag) begin
      doneFlag = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!doneFlag) begin
      doneFlag = 1'b1;
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule